// File: doc/BRIEF.md
# DTMF Transceiver Host Register Port

This block is the host-side register interface of a tone-signalling transceiver. A processor on a 4-bit, strobe-qualified bus reaches five registers through one register-select line and a read/write line. It writes a transmit code and two control words, and it reads a received code and a status word. The tone generator and the tone detector sit outside the block. They see only a transmit code with a load pulse, a few mode outputs, a received code with its valid strobe, a tone-gone strobe and a burst-finished strobe.

Both control words share one address. Setting the select bit in the first control word sends the next control write, and only that one, to the second word. The status word gathers sticky event flags. Reading it returns the flags as they stood and then clears them. An active-low interrupt follows the flags whenever interrupts are enabled.

The bus strobe may be asynchronous to the block clock. A parameter inserts a synchronizer of SYNC_STAGES registers on the whole bus bundle, or none, before the access is acted on. Each falling edge of the strobe with chip select low is one access.

Top module: `dtmf_host_port`

## Requirements
- R1: After reset irq_n is 1, d_oe is 0, tx_code is 0, tone_en and cp_mode are 0 and burst_en is 1. All status flags are clear and the control-B select is not pending.
- R2: An access with rs0=0, rw=0 loads d_in into tx_code and pulses tx_load high for exactly one clock.
- R3: A rx_valid pulse loads rx_code into the receive register. A read with rs0=0, rw=1 drives that register on d_out.
- R4: A control write (rs0=1, rw=0) with no select pending updates control word A: bit0 drives tone_en, bit1 drives cp_mode, bit2 is interrupt enable and bit3 is the select.
- R5: A control-A write with bit3=1 routes the next control write to control word B, whose bit0=1 clears burst_en. Word A keeps its value, and the control write after that goes to A again.
- R6: Status bit2 sets on rx_valid and bit3 sets on tone_absent. Bit1 sets on burst_done only while burst_en=1, and it is held 0 while burst_en=0.
- R7: A status read (rs0=1, rw=1) drives {bit3, bit2, bit1, bit0=interrupt active} as they stood before the access. Bits 1 to 3 clear at the end of the access.
- R8: A flag event in the same clock as the clearing status access wins, so the flag stays set.
- R9: irq_n is 0 exactly when interrupt enable is 1 and status bit1 or bit2 is set.
- R10: d_oe is 1 only while phi2=1, cs_n=0 and rw=1, and d_out is 0 otherwise. An access with cs_n=1 changes no register and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Bus strobe; access taken on its falling edge |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| rs0 | input | 1 | Register select: 0 data, 1 control/status |
| d_in | input | DATA_W | Write data from host |
| d_out | output | DATA_W | Read data to host |
| d_oe | output | 1 | Read data enable for the bus driver |
| irq_n | output | 1 | Active-low interrupt |
| tx_code | output | DATA_W | Code for the tone generator |
| tx_load | output | 1 | One-clock pulse after a transmit write |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode select |
| burst_en | output | 1 | Timed burst mode active |
| rx_code | input | DATA_W | Decoded code from the detector |
| rx_valid | input | 1 | Strobe: rx_code is valid |
| tone_absent | input | 1 | Strobe: tone gone, validated |
| burst_done | input | 1 | Strobe: transmit burst finished |

## Verification
The collision that matters is a status read that clears the flags landing in the same clock as a detector strobe that sets one. The bench provokes it by timing an rx_valid pulse to the exact clock in which the synchronized strobe fall is acted on. The read itself must return the flag still clear. The next status read must show bit2 set and the interrupt active, and the receive register must hold the colliding code. A cycle-by-cycle behavioural model judges every other clock around that event.

// File: rtl/dtmf_port_pkg.sv
package dtmf_port_pkg;

   // access kind, encoded as {rs0, rw}
   typedef enum logic [1:0] {
      ACC_TX_WR   = 2'b00,
      ACC_RX_RD   = 2'b01,
      ACC_CTRL_WR = 2'b10,
      ACC_STAT_RD = 2'b11
   } acc_kind_t;

   // control word A fields
   localparam int unsigned CA_TONE = 0;
   localparam int unsigned CA_CPRG = 1;
   localparam int unsigned CA_IEN  = 2;
   localparam int unsigned CA_SEL  = 3;
   // control word B fields
   localparam int unsigned CB_NOBURST = 0;
   // status word fields
   localparam int unsigned ST_IRQ = 0;
   localparam int unsigned ST_RDY = 1;
   localparam int unsigned ST_RXV = 2;
   localparam int unsigned ST_ABS = 3;

   // bus bundle layout inside the synchronizer
   localparam int unsigned BB_PHI = 0;
   localparam int unsigned BB_CSN = 1;
   localparam int unsigned BB_RW  = 2;
   localparam int unsigned BB_RS  = 3;
   localparam int unsigned BB_D   = 4;

endpackage

// File: rtl/dtmf_port_sync.sv
module dtmf_port_sync
   import dtmf_port_pkg::*;
#(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              cs_n,
   input  logic              rw,
   input  logic              rs0,
   input  logic [DATA_W-1:0] d_in,
   output logic              acc_fire,
   output acc_kind_t         acc_kind,
   output logic [DATA_W-1:0] acc_data
);

   localparam int unsigned BW = DATA_W + BB_D;
   localparam logic [BW-1:0] IDLE = BW'(1) << BB_CSN;

   logic [BW-1:0] live;
   logic [BW-1:0] dly;
   logic          phi_prev;

   assign live = {d_in, rs0, rw, cs_n, phi2};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign dly = live;
      end else begin : g_pipe
         logic [BW-1:0] pipe [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) pipe[k] <= IDLE;
            end else begin
               pipe[0] <= live;
               for (int k = 1; k < SYNC_STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign dly = pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phi_prev <= 1'b0;
      else        phi_prev <= dly[BB_PHI];
   end

   assign acc_fire = phi_prev & ~dly[BB_PHI] & ~dly[BB_CSN];
   assign acc_kind = acc_kind_t'({dly[BB_RS], dly[BB_RW]});
   assign acc_data = dly[BB_D +: DATA_W];

endmodule

// File: rtl/dtmf_port_ctrl.sv
module dtmf_port_ctrl
   import dtmf_port_pkg::*;
#(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_fire,
   input  acc_kind_t         acc_kind,
   input  logic [DATA_W-1:0] acc_data,
   output logic [DATA_W-1:0] tx_code,
   output logic              tx_load,
   output logic              tone_en,
   output logic              cp_mode,
   output logic              irq_en,
   output logic              burst_en,
   output logic              sel_pend
);

   logic wr_tx;
   logic wr_ctl;
   logic no_burst;

   assign wr_tx  = acc_fire && (acc_kind == ACC_TX_WR);
   assign wr_ctl = acc_fire && (acc_kind == ACC_CTRL_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_code <= '0;
         tx_load <= 1'b0;
      end else begin
         tx_load <= wr_tx;
         if (wr_tx) tx_code <= acc_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tone_en  <= 1'b0;
         cp_mode  <= 1'b0;
         irq_en   <= 1'b0;
         sel_pend <= 1'b0;
         no_burst <= 1'b0;
      end else if (wr_ctl) begin
         if (sel_pend) begin
            no_burst <= acc_data[CB_NOBURST];
            sel_pend <= 1'b0;
         end else begin
            tone_en  <= acc_data[CA_TONE];
            cp_mode  <= acc_data[CA_CPRG];
            irq_en   <= acc_data[CA_IEN];
            sel_pend <= acc_data[CA_SEL];
         end
      end
   end

   assign burst_en = ~no_burst;

endmodule

// File: rtl/dtmf_port_status.sv
module dtmf_port_status
   import dtmf_port_pkg::*;
#(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_fire,
   input  acc_kind_t         acc_kind,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_code,
   input  logic              tone_absent,
   input  logic              burst_done,
   input  logic              burst_en,
   input  logic              irq_en,
   output logic [DATA_W-1:0] rxd_q,
   output logic              rdy_flag,
   output logic              rxv_flag,
   output logic              abs_flag,
   output logic [DATA_W-1:0] stat_word,
   output logic              irq_n
);

   logic rd_clr;
   logic irq_act;

   assign rd_clr = acc_fire && (acc_kind == ACC_STAT_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_flag <= 1'b0;
         rxv_flag <= 1'b0;
         abs_flag <= 1'b0;
         rxd_q    <= '0;
      end else begin
         // an event in the clearing clock takes precedence
         if (!burst_en)       rdy_flag <= 1'b0;
         else if (burst_done) rdy_flag <= 1'b1;
         else if (rd_clr)     rdy_flag <= 1'b0;

         if (rx_valid)        rxv_flag <= 1'b1;
         else if (rd_clr)     rxv_flag <= 1'b0;

         if (tone_absent)     abs_flag <= 1'b1;
         else if (rd_clr)     abs_flag <= 1'b0;

         if (rx_valid)        rxd_q <= rx_code;
      end
   end

   assign irq_act = irq_en & (rdy_flag | rxv_flag);
   assign irq_n   = ~irq_act;

   always_comb begin
      stat_word         = '0;
      stat_word[ST_IRQ] = irq_act;
      stat_word[ST_RDY] = rdy_flag;
      stat_word[ST_RXV] = rxv_flag;
      stat_word[ST_ABS] = abs_flag;
   end

endmodule

// File: rtl/dtmf_host_port.sv
module dtmf_host_port
   import dtmf_port_pkg::*;
#(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              cs_n,
   input  logic              rw,
   input  logic              rs0,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   output logic              irq_n,
   output logic [DATA_W-1:0] tx_code,
   output logic              tx_load,
   output logic              tone_en,
   output logic              cp_mode,
   output logic              burst_en,
   input  logic [DATA_W-1:0] rx_code,
   input  logic              rx_valid,
   input  logic              tone_absent,
   input  logic              burst_done
);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("dtmf_host_port: DATA_W must be at least 4");
      end
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("dtmf_host_port: SYNC_STAGES above 8 is not supported");
      end
   endgenerate

   logic              acc_fire;
   acc_kind_t         acc_kind;
   logic [DATA_W-1:0] acc_data;
   logic              irq_en;
   logic              sel_pend;
   logic [DATA_W-1:0] rxd_q;
   logic              rdy_flag;
   logic              rxv_flag;
   logic              abs_flag;
   logic [DATA_W-1:0] stat_word;

   dtmf_port_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi2     (phi2),
      .cs_n     (cs_n),
      .rw       (rw),
      .rs0      (rs0),
      .d_in     (d_in),
      .acc_fire (acc_fire),
      .acc_kind (acc_kind),
      .acc_data (acc_data)
   );

   dtmf_port_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_fire (acc_fire),
      .acc_kind (acc_kind),
      .acc_data (acc_data),
      .tx_code  (tx_code),
      .tx_load  (tx_load),
      .tone_en  (tone_en),
      .cp_mode  (cp_mode),
      .irq_en   (irq_en),
      .burst_en (burst_en),
      .sel_pend (sel_pend)
   );

   dtmf_port_status #(.DATA_W(DATA_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_fire    (acc_fire),
      .acc_kind    (acc_kind),
      .rx_valid    (rx_valid),
      .rx_code     (rx_code),
      .tone_absent (tone_absent),
      .burst_done  (burst_done),
      .burst_en    (burst_en),
      .irq_en      (irq_en),
      .rxd_q       (rxd_q),
      .rdy_flag    (rdy_flag),
      .rxv_flag    (rxv_flag),
      .abs_flag    (abs_flag),
      .stat_word   (stat_word),
      .irq_n       (irq_n)
   );

   // read data is live while the strobe is high; selection uses the live rs0
   assign d_oe  = phi2 & ~cs_n & rw;
   assign d_out = d_oe ? (rs0 ? stat_word : rxd_q) : '0;

endmodule

// File: rtl/dtmf_host_port_chk.sv
module dtmf_host_port_chk
   import dtmf_port_pkg::*;
#(
   parameter int unsigned DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_fire,
   input acc_kind_t         acc_kind,
   input logic [DATA_W-1:0] acc_data,
   input logic              sel_pend,
   input logic              irq_en,
   input logic              irq_n,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_code,
   input logic [DATA_W-1:0] rxd_q,
   input logic              rxv_flag,
   input logic              rdy_flag,
   input logic              burst_en,
   input logic              tx_load
);

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> irq_en);                                                         // R9

   AST_RXD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (rxd_q == $past(rx_code)));                                    // R3

   AST_RX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> rxv_flag);                                                     // R8

   AST_READY_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_en |=> !rdy_flag);                                                   // R6

   AST_B_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && acc_kind == ACC_CTRL_WR && sel_pend) |=> !sel_pend);           // R5

   AST_B_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fire && acc_kind == ACC_CTRL_WR && !sel_pend && acc_data[CA_SEL]) |=> sel_pend); // R5

   AST_TX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);                                                      // R2

endmodule

bind dtmf_host_port dtmf_host_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_fire (acc_fire),
   .acc_kind (acc_kind),
   .acc_data (acc_data),
   .sel_pend (sel_pend),
   .irq_en   (irq_en),
   .irq_n    (irq_n),
   .rx_valid (rx_valid),
   .rx_code  (rx_code),
   .rxd_q    (rxd_q),
   .rxv_flag (rxv_flag),
   .rdy_flag (rdy_flag),
   .burst_en (burst_en),
   .tx_load  (tx_load)
);

// File: tb/dtmf_host_port_test.sv
`timescale 1ns/1ps
module dtmf_host_port_test;

   localparam int DW     = 4;
   localparam int STAGES = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          phi2 = 1'b0;
   logic          cs_n = 1'b1;
   logic          rw = 1'b0;
   logic          rs0 = 1'b0;
   logic [DW-1:0] d_in = '0;
   logic [DW-1:0] d_out;
   logic          d_oe;
   logic          irq_n;
   logic [DW-1:0] tx_code;
   logic          tx_load;
   logic          tone_en;
   logic          cp_mode;
   logic          burst_en;
   logic [DW-1:0] rx_code = '0;
   logic          rx_valid = 1'b0;
   logic          tone_absent = 1'b0;
   logic          burst_done = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dtmf_host_port #(.DATA_W(DW), .SYNC_STAGES(STAGES)) uut (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_n(cs_n), .rw(rw), .rs0(rs0),
      .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .irq_n(irq_n),
      .tx_code(tx_code), .tx_load(tx_load), .tone_en(tone_en),
      .cp_mode(cp_mode), .burst_en(burst_en), .rx_code(rx_code),
      .rx_valid(rx_valid), .tone_absent(tone_absent), .burst_done(burst_done)
   );

   // behavioural reference model
   int q[$];
   int m_prev, m_tone, m_cp, m_ie, m_pend, m_nob, m_tx, m_txl;
   int m_rdy, m_rxv, m_abs, m_rxd;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         for (int i = 0; i < STAGES; i++) q.push_back(2);
         m_prev = 0; m_tone = 0; m_cp = 0; m_ie = 0; m_pend = 0; m_nob = 0;
         m_tx = 0; m_txl = 0; m_rdy = 0; m_rxv = 0; m_abs = 0; m_rxd = 0;
      end else begin
         int cur, dl, fire, kind, dat;
         cur = int'(phi2) | (int'(cs_n) << 1) | (int'(rw) << 2) | (int'(rs0) << 3) | (int'(d_in) << 4);
         dl = (STAGES == 0) ? cur : q[STAGES-1];
         fire = (m_prev == 1 && (dl & 1) == 0 && (dl & 2) == 0) ? 1 : 0;
         kind = (dl >> 2) & 3;          // {rs0, rw}
         dat  = (dl >> 4) & 15;
         if (m_nob == 1)       m_rdy = 0;
         else if (burst_done)  m_rdy = 1;
         else if (fire == 1 && kind == 3) m_rdy = 0;
         if (rx_valid)         m_rxv = 1;
         else if (fire == 1 && kind == 3) m_rxv = 0;
         if (tone_absent)      m_abs = 1;
         else if (fire == 1 && kind == 3) m_abs = 0;
         if (rx_valid)         m_rxd = int'(rx_code);
         m_txl = (fire == 1 && kind == 0) ? 1 : 0;
         if (m_txl == 1) m_tx = dat;
         if (fire == 1 && kind == 2) begin
            if (m_pend == 1) begin
               m_nob = dat & 1; m_pend = 0;
            end else begin
               m_tone = dat & 1; m_cp = (dat >> 1) & 1; m_ie = (dat >> 2) & 1;
               m_pend = (dat >> 3) & 1;
            end
         end
         m_prev = dl & 1;
         if (STAGES > 0) begin
            q.push_front(cur);
            void'(q.pop_back());
         end
      end
   end

   function automatic int m_stat();
      int act;
      act = (m_ie == 1 && (m_rdy == 1 || m_rxv == 1)) ? 1 : 0;
      return (m_abs << 3) | (m_rxv << 2) | (m_rdy << 1) | act;
   endfunction

   task automatic cmp(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
      end
   endtask

   // per-clock comparison, away from both edges
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int oe, dexp;
         #3;
         oe = (phi2 && !cs_n && rw) ? 1 : 0;
         dexp = (oe == 1) ? (rs0 ? m_stat() : m_rxd) : 0;
         cmp("R10", "model d_oe", int'(d_oe), oe);
         cmp(rs0 ? "R7" : "R3", "model d_out", int'(d_out), dexp);
         cmp("R9", "model irq_n", int'(irq_n), (m_stat() & 1) ? 0 : 1);
         cmp("R2", "model tx_code", int'(tx_code), m_tx);
         cmp("R2", "model tx_load", int'(tx_load), m_txl);
         cmp("R4", "model tone_en", int'(tone_en), m_tone);
         cmp("R4", "model cp_mode", int'(cp_mode), m_cp);
         cmp("R5", "model burst_en", int'(burst_en), 1 - m_nob);
      end
   end

   task automatic bus_op(input int rs, input int r, input int dat, input int csn,
                         input int coll, output int rdval);
      @(negedge clk);
      cs_n = csn[0]; rs0 = rs[0]; rw = r[0]; d_in = DW'(dat); phi2 = 1'b1;
      @(negedge clk);
      @(negedge clk);
      #1 rdval = int'(d_out);
      phi2 = 1'b0;
      if (coll >= 0) begin
         repeat (STAGES) @(negedge clk);
         rx_code = DW'(coll); rx_valid = 1'b1;
         @(negedge clk);
         rx_valid = 1'b0;
      end
      repeat (STAGES + 2) @(negedge clk);
      cs_n = 1'b1; rw = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse(input int which, input int code);
      @(negedge clk);
      rx_code = DW'(code);
      if (which == 0) rx_valid = 1'b1;
      if (which == 1) tone_absent = 1'b1;
      if (which == 2) burst_done = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; tone_absent = 1'b0; burst_done = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int rd;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      cmp("R1", "reset irq_n", int'(irq_n), 1);
      cmp("R1", "reset d_oe", int'(d_oe), 0);
      cmp("R1", "reset tx_code", int'(tx_code), 0);
      cmp("R1", "reset tone_en", int'(tone_en), 0);
      cmp("R1", "reset cp_mode", int'(cp_mode), 0);
      cmp("R1", "reset burst_en", int'(burst_en), 1);
      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R1", "reset status", rd, 0);

      bus_op(0, 0, 5, 0, -1, rd);
      cmp("R2", "tx_code after write", int'(tx_code), 5);

      pulse(0, 9);
      bus_op(0, 1, 0, 0, -1, rd);
      cmp("R3", "rx data read", rd, 9);

      bus_op(1, 0, 7, 0, -1, rd);
      cmp("R4", "tone_en", int'(tone_en), 1);
      cmp("R4", "cp_mode", int'(cp_mode), 1);
      cmp("R9", "irq_n with rx flag", int'(irq_n), 0);

      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R7", "status pre-clear", rd, 5);
      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R7", "status after clear", rd, 0);
      cmp("R9", "irq_n after clear", int'(irq_n), 1);

      pulse(1, 0);
      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R6", "tone-absent flag", rd, 8);

      pulse(2, 0);
      cmp("R9", "irq_n on burst done", int'(irq_n), 0);
      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R6", "burst ready flag", rd, 3);

      bus_op(1, 0, 13, 0, -1, rd);
      cmp("R4", "A write with select", int'(cp_mode), 0);
      bus_op(1, 0, 1, 0, -1, rd);
      cmp("R5", "B write burst_en", int'(burst_en), 0);
      cmp("R5", "A kept tone_en", int'(tone_en), 1);
      bus_op(1, 0, 2, 0, -1, rd);
      cmp("R5", "back to A tone_en", int'(tone_en), 0);
      cmp("R5", "back to A cp_mode", int'(cp_mode), 1);
      cmp("R5", "burst_en kept", int'(burst_en), 0);

      pulse(2, 0);
      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R6", "ready held low without burst", rd, 0);

      bus_op(0, 0, 15, 1, -1, rd);
      cmp("R10", "deselected write ignored", int'(tx_code), 5);
      bus_op(1, 1, 0, 1, -1, rd);
      cmp("R10", "deselected read bus idle", rd, 0);
      pulse(0, 3);
      bus_op(1, 1, 0, 1, -1, rd);
      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R10", "deselected read kept flag", rd, 4);

      bus_op(1, 0, 4, 0, -1, rd);
      bus_op(1, 1, 0, 0, 10, rd);
      cmp("R8", "colliding read value", rd, 0);
      bus_op(1, 1, 0, 0, -1, rd);
      cmp("R8", "flag survives collision", rd, 5);
      bus_op(0, 1, 0, 0, -1, rd);
      cmp("R3", "colliding code captured", rd, 10);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule